// File: doc/BRIEF.md
# Boundary-Scan Test Access Port with System-Reset Pin Float

This block is a test access port controller for boundary scan. It runs the standard sixteen-state TAP state machine from the scan clock and mode inputs. An 8-bit instruction register chooses which data register sits between the serial input and output. The choices are a one-bit bypass register, a 32-bit identification register, and a boundary register that covers a small bank of output pins. Each pin has three boundary cells: one for its input, one for its output data and one for its output enable.

The pins normally carry the core's output and enable values. Under the external-test and clamp instructions they are driven from the boundary update cells instead, and the high-impedance instruction floats them. A system reset input, separate from the scan reset, overrides all of this. While it is asserted every pin is floated, whatever instruction is loaded and whatever the boundary cells hold. Scan data is sampled on the rising scan-clock edge, and the serial output is launched on the falling edge.

Top module: `bscan_tap`

## Requirements
- R1: While trstN is low the controller is held in Test-Logic-Reset, and while in that state the instruction register holds the identification opcode 0x02.
- R2: From any state, five consecutive rising edges of tck with tms high bring the controller to Test-Logic-Reset.
- R3: The instruction register is 8 bits wide and is shifted LSB first, with tdi entering at the MSB. Capture-IR loads the binary value 00000001. The active instruction changes only in Update-IR or Test-Logic-Reset.
- R4: The opcodes are 0x00 external test, 0x01 sample/preload, 0x02 identification, 0x03 clamp, 0x04 high-impedance and 0xFF bypass. Clamp, high-impedance, bypass and every other code select the bypass register.
- R5: The bypass register is one bit wide. It captures 0 in Capture-DR, so the output during Shift-DR is 0 followed by tdi delayed by one shift.
- R6: The identification register captures parameter ID_VALUE with bit 0 forced to 1, and it shifts out LSB first.
- R7: The boundary register is 3*NUM_PINS bits long. Bit i is pinIn[i], bit NUM_PINS+i is coreOut[i], and bit 2*NUM_PINS+i is coreOe[i]. Bit 0 is nearest tdo. Its update cells load from the data and enable fields in Update-DR, and only under external test or sample/preload.
- R8: tdo and tdoOe change only on falling tck edges. tdoOe is 1 only in Shift-IR and Shift-DR, and tdo is 0 whenever tdoOe is 0.
- R9: With sysRst low, external test and clamp drive pinOut and pinOe from the update cells. High-impedance gives pinOe = 0 and pinOut = 0. All other instructions pass coreOut and coreOe through.
- R10: While sysRst is high, pinOe and pinOut are all 0, whatever the instruction and the boundary cells hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Scan clock |
| trstN | input | 1 | Asynchronous scan reset, active low |
| tms | input | 1 | Scan mode select, sampled on the rising tck edge |
| tdi | input | 1 | Serial scan data in, sampled on the rising tck edge |
| sysRst | input | 1 | System reset; floats every controlled pin while high |
| coreOut | input | NUM_PINS | Core output data for the pins |
| coreOe | input | NUM_PINS | Core output enables for the pins |
| pinIn | input | NUM_PINS | Values seen at the pins |
| tdo | output | 1 | Serial scan data out, launched on the falling tck edge |
| tdoOe | output | 1 | Enable for tdo |
| pinOut | output | NUM_PINS | Data toward the pin drivers |
| pinOe | output | NUM_PINS | Enables toward the pin drivers |

## Verification
Two functions can act in the same cycle: the boundary drive under external test or clamp, and the system-reset float. The bench first preloads a nonzero pattern into the update cells. It then loads external test, and later clamp, and raises sysRst with that pattern still in place and while scan shifts are running. A behavioural reference model, compared on every tck cycle, expects both pinOe and pinOut to be 0 in those cycles. It expects the preloaded pattern to come back as soon as sysRst falls, with no rescan.

// File: rtl/bscan_pkg.sv
package bscan_pkg;
  localparam int IR_W = 8;

  typedef enum logic [3:0] {
    ST_RESET, ST_IDLE, ST_SELDR, ST_CAPDR, ST_SHDR, ST_EX1DR, ST_PAUDR, ST_EX2DR, ST_UPDDR,
    ST_SELIR, ST_CAPIR, ST_SHIR, ST_EX1IR, ST_PAUIR, ST_EX2IR, ST_UPDIR
  } tap_state_e;

  typedef enum logic [1:0] {SEL_BYP, SEL_ID, SEL_BSR} dr_sel_e;
  typedef enum logic [1:0] {PM_CORE, PM_DRIVE, PM_FLOAT} pin_mode_e;

  localparam logic [IR_W-1:0] OP_EXTEST = 8'h00;
  localparam logic [IR_W-1:0] OP_SAMPLE = 8'h01;
  localparam logic [IR_W-1:0] OP_IDCODE = 8'h02;
  localparam logic [IR_W-1:0] OP_CLAMP  = 8'h03;
  localparam logic [IR_W-1:0] OP_HIGHZ  = 8'h04;
  localparam logic [IR_W-1:0] OP_BYPASS = 8'hFF;

  typedef struct packed {
    logic      capDr;
    logic      shDr;
    logic      updDr;
    logic      shIr;
    logic      irSo;
    logic      bsrUpdEn;
    dr_sel_e   drSel;
    pin_mode_e pinMode;
  } tap_strobe_t;
endpackage

// File: rtl/bscan_ctrl.sv
module bscan_ctrl
  import bscan_pkg::*;
(
  input  logic        tck,
  input  logic        trstN,
  input  logic        tms,
  input  logic        tdi,
  output tap_strobe_t strb
);
  tap_state_e state, nextState;
  logic [IR_W-1:0] irShift, irReg;

  always_comb begin
    case (state)
      ST_RESET: nextState = tms ? ST_RESET : ST_IDLE;
      ST_IDLE:  nextState = tms ? ST_SELDR : ST_IDLE;
      ST_SELDR: nextState = tms ? ST_SELIR : ST_CAPDR;
      ST_CAPDR: nextState = tms ? ST_EX1DR : ST_SHDR;
      ST_SHDR:  nextState = tms ? ST_EX1DR : ST_SHDR;
      ST_EX1DR: nextState = tms ? ST_UPDDR : ST_PAUDR;
      ST_PAUDR: nextState = tms ? ST_EX2DR : ST_PAUDR;
      ST_EX2DR: nextState = tms ? ST_UPDDR : ST_SHDR;
      ST_UPDDR: nextState = tms ? ST_SELDR : ST_IDLE;
      ST_SELIR: nextState = tms ? ST_RESET : ST_CAPIR;
      ST_CAPIR: nextState = tms ? ST_EX1IR : ST_SHIR;
      ST_SHIR:  nextState = tms ? ST_EX1IR : ST_SHIR;
      ST_EX1IR: nextState = tms ? ST_UPDIR : ST_PAUIR;
      ST_PAUIR: nextState = tms ? ST_EX2IR : ST_PAUIR;
      ST_EX2IR: nextState = tms ? ST_UPDIR : ST_SHIR;
      ST_UPDIR: nextState = tms ? ST_SELDR : ST_IDLE;
      default:  nextState = ST_RESET;
    endcase
  end

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) state <= ST_RESET;
    else        state <= nextState;
  end

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) begin
      irShift <= '0;
      irReg   <= OP_IDCODE;
    end else begin
      case (state)
        ST_RESET: irReg   <= OP_IDCODE;
        ST_CAPIR: irShift <= {{(IR_W-2){1'b0}}, 2'b01};
        ST_SHIR:  irShift <= {tdi, irShift[IR_W-1:1]};
        ST_UPDIR: irReg   <= irShift;
        default: ;
      endcase
    end
  end

  // instruction decode
  dr_sel_e   drSel;
  pin_mode_e pinMode;
  logic      bsrUpdEn;
  always_comb begin
    drSel    = SEL_BYP;
    pinMode  = PM_CORE;
    bsrUpdEn = 1'b0;
    case (irReg)
      OP_EXTEST: begin drSel = SEL_BSR; pinMode = PM_DRIVE; bsrUpdEn = 1'b1; end
      OP_SAMPLE: begin drSel = SEL_BSR; bsrUpdEn = 1'b1; end
      OP_IDCODE: drSel = SEL_ID;
      OP_CLAMP:  pinMode = PM_DRIVE;
      OP_HIGHZ:  pinMode = PM_FLOAT;
      default: ;
    endcase
  end

  assign strb.capDr    = (state == ST_CAPDR);
  assign strb.shDr     = (state == ST_SHDR);
  assign strb.updDr    = (state == ST_UPDDR);
  assign strb.shIr     = (state == ST_SHIR);
  assign strb.irSo     = irShift[0];
  assign strb.bsrUpdEn = bsrUpdEn;
  assign strb.drSel    = drSel;
  assign strb.pinMode  = pinMode;

  p_five_tms_r2: assert property (@(posedge tck) disable iff (!trstN)
    (tms && $past(tms, 1) && $past(tms, 2) && $past(tms, 3) && $past(tms, 4)) |=> state == ST_RESET);

  p_capture_ir_r3: assert property (@(posedge tck) disable iff (!trstN)
    state == ST_CAPIR |=> irShift[1:0] == 2'b01);

  p_ir_hold_r3: assert property (@(posedge tck) disable iff (!trstN)
    (state != ST_UPDIR && state != ST_RESET) |=> $stable(irReg));

  p_reset_ir_r1: assert property (@(posedge tck) disable iff (!trstN)
    state == ST_RESET |=> irReg == OP_IDCODE);
endmodule

// File: rtl/bscan_dpath.sv
module bscan_dpath
  import bscan_pkg::*;
#(
  parameter int          NUM_PINS = 4,
  parameter logic [31:0] ID_VALUE = 32'h4B5A_1C2D
) (
  input  logic                tck,
  input  logic                trstN,
  input  logic                tdi,
  input  logic                sysRst,
  input  tap_strobe_t         strb,
  input  logic [NUM_PINS-1:0] coreOut,
  input  logic [NUM_PINS-1:0] coreOe,
  input  logic [NUM_PINS-1:0] pinIn,
  output logic                tdo,
  output logic                tdoOe,
  output logic [NUM_PINS-1:0] pinOut,
  output logic [NUM_PINS-1:0] pinOe
);
  localparam int          BSR_LEN = 3 * NUM_PINS;
  localparam logic [31:0] ID_WORD = ID_VALUE | 32'd1;

  logic                bypassBit;
  logic [31:0]         idShift;
  logic [BSR_LEN-1:0]  bsrShift, bsrCap;
  logic [NUM_PINS-1:0] updData, updEn;
  logic                drSo;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_cell
    assign bsrCap[p]              = pinIn[p];
    assign bsrCap[NUM_PINS + p]   = coreOut[p];
    assign bsrCap[2*NUM_PINS + p] = coreOe[p];
  end

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) begin
      bypassBit <= 1'b0;
      idShift   <= '0;
      bsrShift  <= '0;
    end else if (strb.capDr) begin
      case (strb.drSel)
        SEL_ID:  idShift   <= ID_WORD;
        SEL_BSR: bsrShift  <= bsrCap;
        default: bypassBit <= 1'b0;
      endcase
    end else if (strb.shDr) begin
      case (strb.drSel)
        SEL_ID:  idShift   <= {tdi, idShift[31:1]};
        SEL_BSR: bsrShift  <= {tdi, bsrShift[BSR_LEN-1:1]};
        default: bypassBit <= tdi;
      endcase
    end
  end

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) begin
      updData <= '0;
      updEn   <= '0;
    end else if (strb.updDr && strb.bsrUpdEn) begin
      updData <= bsrShift[NUM_PINS +: NUM_PINS];
      updEn   <= bsrShift[2*NUM_PINS +: NUM_PINS];
    end
  end

  always_comb begin
    case (strb.drSel)
      SEL_ID:  drSo = idShift[0];
      SEL_BSR: drSo = bsrShift[0];
      default: drSo = bypassBit;
    endcase
  end

  always_ff @(negedge tck or negedge trstN) begin
    if (!trstN) begin
      tdo   <= 1'b0;
      tdoOe <= 1'b0;
    end else if (strb.shIr) begin
      tdo   <= strb.irSo;
      tdoOe <= 1'b1;
    end else if (strb.shDr) begin
      tdo   <= drSo;
      tdoOe <= 1'b1;
    end else begin
      tdo   <= 1'b0;
      tdoOe <= 1'b0;
    end
  end

  // system reset wins over every boundary mode
  always_comb begin
    if (sysRst) begin
      pinOut = '0;
      pinOe  = '0;
    end else begin
      case (strb.pinMode)
        PM_DRIVE: begin pinOut = updData; pinOe = updEn; end
        PM_FLOAT: begin pinOut = '0;      pinOe = '0;    end
        default:  begin pinOut = coreOut; pinOe = coreOe; end
      endcase
    end
  end

  always_comb begin
    if (sysRst === 1'b1 && strb.pinMode == PM_DRIVE)
      p_sysrst_float_r10: assert (pinOe == '0 && pinOut == '0);
  end

  p_highz_float_r9: assert property (@(posedge tck) disable iff (!trstN)
    (!sysRst && strb.pinMode == PM_FLOAT) |-> pinOe == '0);

  p_upd_hold_r7: assert property (@(posedge tck) disable iff (!trstN)
    !strb.updDr |=> ($stable(updData) && $stable(updEn)));

  p_id_lsb_r6: assert property (@(posedge tck) disable iff (!trstN)
    (strb.capDr && strb.drSel == SEL_ID) |=> idShift[0] == 1'b1);
endmodule

// File: rtl/bscan_tap.sv
module bscan_tap
  import bscan_pkg::*;
#(
  parameter int          NUM_PINS = 4,
  parameter logic [31:0] ID_VALUE = 32'h4B5A_1C2D
) (
  input  logic                tck,
  input  logic                trstN,
  input  logic                tms,
  input  logic                tdi,
  input  logic                sysRst,
  input  logic [NUM_PINS-1:0] coreOut,
  input  logic [NUM_PINS-1:0] coreOe,
  input  logic [NUM_PINS-1:0] pinIn,
  output logic                tdo,
  output logic                tdoOe,
  output logic [NUM_PINS-1:0] pinOut,
  output logic [NUM_PINS-1:0] pinOe
);
  tap_strobe_t strb;

  bscan_ctrl u_ctrl (
    .tck(tck), .trstN(trstN), .tms(tms), .tdi(tdi), .strb(strb)
  );

  bscan_dpath #(.NUM_PINS(NUM_PINS), .ID_VALUE(ID_VALUE)) u_dpath (
    .tck(tck), .trstN(trstN), .tdi(tdi), .sysRst(sysRst), .strb(strb),
    .coreOut(coreOut), .coreOe(coreOe), .pinIn(pinIn),
    .tdo(tdo), .tdoOe(tdoOe), .pinOut(pinOut), .pinOe(pinOe)
  );
endmodule

// File: tb/sim_bscan_tap.sv
module sim_bscan_tap;
  localparam int          NP  = 4;
  localparam logic [31:0] IDV = 32'h4B5A_1C2C; // bit 0 deliberately 0: R6 forces it

  logic tck = 1'b0, trstN = 1'b0, tms = 1'b1, tdi = 1'b0, sysRst = 1'b0;
  logic [NP-1:0] coreOut = '0, coreOe = '0, pinIn = '0;
  logic tdo, tdoOe;
  logic [NP-1:0] pinOut, pinOe;

  int nChk = 0, nErr = 0;

  always #10 tck = ~tck;

  bscan_tap #(.NUM_PINS(NP), .ID_VALUE(IDV)) u0 (
    .tck(tck), .trstN(trstN), .tms(tms), .tdi(tdi), .sysRst(sysRst),
    .coreOut(coreOut), .coreOe(coreOe), .pinIn(pinIn),
    .tdo(tdo), .tdoOe(tdoOe), .pinOut(pinOut), .pinOe(pinOe)
  );

  // behavioural reference model
  int       mSt;
  bit [7:0] mIr;
  bit       mIrQ[$];
  bit       mDrQ[$];
  bit [NP-1:0] mUpdD, mUpdE;
  bit       mTdo, mTdoOe;

  function automatic int nxt(int s, bit t);
    case (s)
      0: return t ? 0 : 1;   1: return t ? 2 : 1;
      2: return t ? 9 : 3;   3: return t ? 5 : 4;
      4: return t ? 5 : 4;   5: return t ? 8 : 6;
      6: return t ? 7 : 6;   7: return t ? 8 : 4;
      8: return t ? 2 : 1;   9: return t ? 0 : 10;
      10: return t ? 12 : 11; 11: return t ? 12 : 11;
      12: return t ? 15 : 13; 13: return t ? 14 : 13;
      14: return t ? 15 : 11; default: return t ? 2 : 1;
    endcase
  endfunction

  task automatic modelRise(input bit t, input bit d);
    bit b;
    case (mSt)
      0: mIr = 8'h02;
      10: begin mIrQ.delete(); mIrQ.push_back(1'b1); repeat (7) mIrQ.push_back(1'b0); end
      11: begin mIrQ.push_back(d); b = mIrQ.pop_front(); end
      15: for (int i = 0; i < 8; i++) mIr[i] = mIrQ[i];
      3: begin
        mDrQ.delete();
        if (mIr == 8'h02) begin
          for (int i = 0; i < 32; i++) mDrQ.push_back(i == 0 ? 1'b1 : IDV[i]);
        end else if (mIr == 8'h00 || mIr == 8'h01) begin
          for (int i = 0; i < NP; i++) mDrQ.push_back(pinIn[i]);
          for (int i = 0; i < NP; i++) mDrQ.push_back(coreOut[i]);
          for (int i = 0; i < NP; i++) mDrQ.push_back(coreOe[i]);
        end else mDrQ.push_back(1'b0);
      end
      4: begin mDrQ.push_back(d); b = mDrQ.pop_front(); end
      8: if (mIr == 8'h00 || mIr == 8'h01)
           for (int i = 0; i < NP; i++) begin mUpdD[i] = mDrQ[NP+i]; mUpdE[i] = mDrQ[2*NP+i]; end
      default: ;
    endcase
    mSt = nxt(mSt, t);
  endtask

  task automatic modelFall();
    if (mSt == 11)     begin mTdo = mIrQ[0]; mTdoOe = 1'b1; end
    else if (mSt == 4) begin mTdo = mDrQ[0]; mTdoOe = 1'b1; end
    else               begin mTdo = 1'b0;    mTdoOe = 1'b0; end
  endtask

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nChk++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic compareAll();
    bit [NP-1:0] eo, ee;
    if (sysRst) begin eo = '0; ee = '0; end
    else if (mIr == 8'h00 || mIr == 8'h03) begin eo = mUpdD; ee = mUpdE; end
    else if (mIr == 8'h04) begin eo = '0; ee = '0; end
    else begin eo = coreOut; ee = coreOe; end
    chk(tdo === mTdo, "R8 tdo", {63'd0, tdo}, {63'd0, mTdo});
    chk(tdoOe === mTdoOe, "R8 tdoOe", {63'd0, tdoOe}, {63'd0, mTdoOe});
    chk(pinOut === eo, sysRst ? "R10 pinOut" : "R9 pinOut", 64'(pinOut), 64'(eo));
    chk(pinOe === ee, sysRst ? "R10 pinOe" : "R9 pinOe", 64'(pinOe), 64'(ee));
  endtask

  task automatic tick(input bit t, input bit d);
    tms = t; tdi = d;
    @(posedge tck);
    modelRise(t, d);
    @(negedge tck);
    modelFall();
    #2;
    compareAll();
  endtask

  task automatic scanReset();
    trstN = 1'b0;
    mSt = 0; mIr = 8'h02; mUpdD = '0; mUpdE = '0; mTdo = 0; mTdoOe = 0;
    mIrQ.delete(); mDrQ.delete();
    @(negedge tck); #2;
    compareAll();
    trstN = 1'b1;
  endtask

  // from Run-Test/Idle, back to Run-Test/Idle
  task automatic shiftIr(input bit [7:0] din, output bit [7:0] dout);
    tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0);
    for (int i = 0; i < 8; i++) begin dout[i] = tdo; tick(i == 7, din[i]); end
    tick(1, 0); tick(0, 0);
  endtask

  task automatic shiftDr(input bit [63:0] din, input int n, output bit [63:0] dout);
    dout = '0;
    tick(1, 0); tick(0, 0); tick(0, 0);
    for (int i = 0; i < n; i++) begin dout[i] = tdo; tick(i == n - 1, din[i]); end
    tick(1, 0); tick(0, 0);
  endtask

  initial begin
    #4_000_000;
    nErr++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("  Result: errors=%0d of %0d checks", nErr, nChk);
    $finish;
  end

  initial begin
    bit [7:0]  ir8;
    bit [63:0] dr;
    coreOut = 4'b1100; coreOe = 4'b1001; pinIn = 4'b0101;
    #3;
    scanReset();
    chk(pinOe === coreOe, "R1 reset pins follow core", 64'(pinOe), 64'(coreOe));
    chk(tdoOe === 1'b0, "R1 tdoOe idle", {63'd0, tdoOe}, 64'd0);
    tick(0, 0);

    // R1/R6: identification selected straight after reset
    shiftDr(64'h0, 32, dr);
    chk(dr[31:0] == (IDV | 32'd1), "R6 id word", dr, 64'(IDV | 32'd1));
    chk(dr[31:0] == (IDV | 32'd1), "R1 reset instruction is id", dr, 64'(IDV | 32'd1));

    // R3: captured instruction pattern, load bypass
    shiftIr(8'hFF, ir8);
    chk(ir8 == 8'h01, "R3 capture-ir value", 64'(ir8), 64'h01);

    // R5: bypass delays by one
    shiftDr(64'hB6D3, 16, dr);
    chk(dr[15:0] == {16'hB6D3 << 1}, "R5 bypass delay", dr, 64'({16'hB6D3 << 1}));

    // R7: sample/preload capture and preload of enables=1111 data=0101
    coreOut = 4'b1010; coreOe = 4'b0110; pinIn = 4'b0011;
    shiftIr(8'h01, ir8);
    shiftDr({52'd0, 4'b1111, 4'b0101, 4'b0000}, 12, dr);
    chk(dr[11:0] == {4'b0110, 4'b1010, 4'b0011}, "R7 boundary capture", dr, 64'({4'b0110, 4'b1010, 4'b0011}));
    chk(pinOe === coreOe, "R9 sample keeps core", 64'(pinOe), 64'(coreOe));

    // R9/R10: external test drives preload; system reset floats it
    shiftIr(8'h00, ir8);
    chk(pinOut === 4'b0101 && pinOe === 4'b1111, "R9 extest drive", 64'({pinOut, pinOe}), 64'h5F);
    sysRst = 1'b1;
    #1;
    chk(pinOe === 4'b0000 && pinOut === 4'b0000, "R10 float under extest", 64'({pinOut, pinOe}), 64'h00);
    shiftDr(64'h0F5, 12, dr); // update cells change while floated
    sysRst = 1'b0;
    #1;
    chk(pinOe === 4'b0000 && pinOut === 4'b1111, "R9 extest new update", 64'({pinOut, pinOe}), 64'hF0);
    shiftDr({52'd0, 4'b1111, 4'b0101, 4'b0000}, 12, dr);

    // R4/R9/R10: clamp holds pins, scans bypass
    shiftIr(8'h03, ir8);
    chk(pinOut === 4'b0101 && pinOe === 4'b1111, "R9 clamp drive", 64'({pinOut, pinOe}), 64'h5F);
    shiftDr(64'h9, 4, dr);
    chk(dr[3:0] == 4'b0010, "R4 clamp selects bypass", dr, 64'h2);
    sysRst = 1'b1;
    tick(0, 0);
    chk(pinOe === 4'b0000, "R10 float under clamp", 64'(pinOe), 64'h0);
    sysRst = 1'b0;
    tick(0, 0);
    chk(pinOe === 4'b1111, "R10 clamp returns after release", 64'(pinOe), 64'hF);

    // R9: high-impedance
    shiftIr(8'h04, ir8);
    chk(pinOe === 4'b0000, "R9 highz floats", 64'(pinOe), 64'h0);

    // R4: undefined opcode
    shiftIr(8'h55, ir8);
    shiftDr(64'h5, 4, dr);
    chk(dr[3:0] == 4'b1010, "R4 undefined selects bypass", dr, 64'hA);
    chk(pinOe === coreOe, "R4 undefined keeps core pins", 64'(pinOe), 64'(coreOe));

    // R2: five tms-high edges from Shift-DR
    shiftIr(8'h00, ir8);
    tick(1, 0); tick(0, 0); tick(0, 0);
    for (int i = 0; i < 5; i++) tick(1, 0);
    tick(0, 0);
    chk(pinOe === coreOe, "R2 back in reset pins core", 64'(pinOe), 64'(coreOe));
    shiftDr(64'h0, 32, dr);
    chk(dr[31:0] == (IDV | 32'd1), "R2 id after tms reset", dr, 64'(IDV | 32'd1));

    // R1: asynchronous scan reset mid-scan
    tick(1, 0); tick(0, 0); tick(0, 0);
    scanReset();
    chk(tdoOe === 1'b0, "R1 trst leaves shift", {63'd0, tdoOe}, 64'd0);

    $display("  Result: errors=%0d of %0d checks", nErr, nChk);
    $finish;
  end
endmodule